// File: doc/BRIEF.md
# Dual-Channel Shared-Bus Stream Transfer Controller

This block sits on the bridge side of a link to a companion device. It moves words between four local FIFO streams and that device over one shared 32-bit bidirectional data bus with an 8-bit address bus. The four streams are a transmit stream and a receive stream for each of two channels. The same bus also carries single-word register reads and writes that a local requester issues. Each channel has its own enable bit. The far side reports for every stream whether it can take part at all (ready) and whether it has room or data for a full burst (burst-ok).

When it grants a stream, the controller sizes the transfer. The transfer is a burst of up to 16 words when the far side reports burst-ok. Otherwise it moves a single word, because the far side is close to its limit. A burst is never longer than the local FIFO can supply or absorb. Streams are served in a fixed rotation. A pending register access takes the bus as soon as the current transfer ends. Whenever the bus reverses direction between two phases, the controller inserts one cycle in which neither strobe is asserted.

A register requester holds `reg_req`, `reg_we`, `reg_addr` and `reg_wdata` steady until it sees `reg_ack`. It must drop `reg_req` no later than the clock edge that follows the ack cycle.

Top module: `xfer_ctl`

## Requirements
- R1: After reset, `xbus_wr`, `xbus_rd`, `reg_ack` and every `tx_rd_en` and `rx_wr_en` bit are low.
- R2: Transmit words of channel c appear on `xbus_data` in FIFO order, one per cycle. Each word comes with `xbus_wr` high, `tx_rd_en[c]` high and `xbus_addr` = 0x80 + stream index. The stream index is 2c for transmit and 2c+1 for receive.
- R3: During a receive cycle for channel c, `xbus_rd` is high and `xbus_addr` = 0x80 + 2c + 1. In the same cycle the word driven by the far side is presented on `rx_wr_data` with `rx_wr_en[c]` high, and the words keep their order.
- R4: No transfer starts on a stream whose channel enable bit in `chan_en` is low. Its local FIFO is left untouched.
- R5: When a stream's `far_burst` bit is high and the local FIFO allows it, words move back to back in one transfer of 16 words. No transfer is ever longer than 16 words.
- R6: When a stream's `far_ready` bit is high and its `far_burst` bit is low, each transfer moves exactly one word.
- R7: A burst is cut to the local transmit fill level (`tx_level`) or the local receive free space (`rx_space`) when that is below 16.
- R8: `xbus_wr` and `xbus_rd` are never high together. A cycle with one of them high is never directly followed by a cycle with the other high.
- R9: Eligible streams are granted in the rotation 0, 1, 2, 3, 0, …, and ineligible streams are skipped. A stream is eligible when its channel is enabled, its `far_ready` bit is high and its local level is non-zero.
- R10: A register write takes one bus cycle with `xbus_wr` high, `xbus_addr` = `reg_addr` and `xbus_data` = `reg_wdata`, and `reg_ack` is high in that cycle.
- R11: A register read takes one bus cycle with `xbus_rd` high and `xbus_addr` = `reg_addr`. `reg_ack` is high in that cycle and `reg_rdata` carries the word the far side drives.
- R12: A register request that arrives during a data transfer is granted right after that transfer's last word, before any other data transfer begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 2 | Per-channel enable bits |
| tx_level | input | 26 | Words held in each transmit FIFO, 13 bits per channel |
| tx_rd_data | input | 64 | Head word of each transmit FIFO, 32 bits per channel |
| tx_rd_en | output | 2 | Pop strobe for each transmit FIFO |
| rx_space | input | 26 | Free words in each receive FIFO, 13 bits per channel |
| rx_wr_en | output | 2 | Push strobe for each receive FIFO |
| rx_wr_data | output | 32 | Word pushed into the receive FIFO |
| far_ready | input | 4 | Far side can move at least one word, one bit per stream |
| far_burst | input | 4 | Far side can move a full burst, one bit per stream |
| reg_req | input | 1 | Register access request |
| reg_we | input | 1 | Register access is a write |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_ack | output | 1 | Register access cycle |
| reg_rdata | output | 32 | Register read data, valid while `reg_ack` is high |
| xbus_addr | output | 8 | Shared bus address |
| xbus_wr | output | 1 | This side drives the data bus |
| xbus_rd | output | 1 | Far side drives the data bus |
| xbus_data | inout | 32 | Shared bidirectional data bus |

## Verification
The transmit path is tried with a long queue under burst-ok, with a 5-word queue, and with burst-ok held low. Together these separate a full 16-word burst from a burst cut by the local fill level and from single-word mode. The receive path is tried with ample free space and with only three free slots. This shows that the burst size follows the local free space rather than the far side's data count. A scenario with every stream active in single-word mode, mixing reads and writes, checks the grant rotation and the idle cycle at each direction change. Register writes and reads, one of them raised in the middle of a burst, show the single-cycle access and the grant that comes right after the burst.

// File: rtl/xfer_pkg.sv
`timescale 1ns/1ps
package xfer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TURN = 2'd1,
        ST_XFER = 2'd2,
        ST_REG  = 2'd3
    } xfer_state_e;
endpackage

// File: rtl/xfer_rr_pick.sv
`timescale 1ns/1ps
module xfer_rr_pick #(
    parameter int N  = 4,
    parameter int SW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [SW-1:0] start,
    output logic          found,
    output logic [SW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int j;
            j = (int'(start) + k) % N;
            if (req[j]) begin
                found = 1'b1;
                idx   = SW'(j);
            end
        end
    end
endmodule

// File: rtl/xfer_len_calc.sv
`timescale 1ns/1ps
module xfer_len_calc #(
    parameter int LVL_W = 13,
    parameter int BMAX  = 16,
    parameter int CW    = 5
) (
    input  logic [LVL_W-1:0] level,
    input  logic             burst_ok,
    output logic [CW-1:0]    len,
    output logic             has_room
);
    localparam logic [LVL_W-1:0] BMAX_L = LVL_W'(BMAX);

    always_comb begin
        has_room = (level != '0);
        if (!burst_ok)
            len = CW'(1);
        else if (level >= BMAX_L)
            len = CW'(BMAX);
        else
            len = CW'(level);
    end
endmodule

// File: rtl/xfer_ctl.sv
`timescale 1ns/1ps
module xfer_ctl #(
    parameter int NCH       = 2,
    parameter int DW        = 32,
    parameter int AW        = 8,
    parameter int LVL_W     = 13,
    parameter int BMAX      = 16,
    parameter int DATA_BASE = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       chan_en,
    input  logic [NCH*LVL_W-1:0] tx_level,
    input  logic [NCH*DW-1:0]    tx_rd_data,
    output logic [NCH-1:0]       tx_rd_en,
    input  logic [NCH*LVL_W-1:0] rx_space,
    output logic [NCH-1:0]       rx_wr_en,
    output logic [DW-1:0]        rx_wr_data,
    input  logic [2*NCH-1:0]     far_ready,
    input  logic [2*NCH-1:0]     far_burst,
    input  logic                 reg_req,
    input  logic                 reg_we,
    input  logic [AW-1:0]        reg_addr,
    input  logic [DW-1:0]        reg_wdata,
    output logic                 reg_ack,
    output logic [DW-1:0]        reg_rdata,
    output logic [AW-1:0]        xbus_addr,
    output logic                 xbus_wr,
    output logic                 xbus_rd,
    inout  wire  [DW-1:0]        xbus_data
);
    import xfer_pkg::*;

    localparam int NSTR = 2 * NCH;
    localparam int SW   = (NSTR > 1) ? $clog2(NSTR) : 1;
    localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int CW   = $clog2(BMAX + 1);

    typedef struct packed {
        xfer_state_e    st;
        logic [SW-1:0]  sel;
        logic           is_reg;
        logic           wr;
        logic [CW-1:0]  cnt;
        logic [SW-1:0]  ptr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NSTR-1:0] elig;
    logic [NSTR-1:0] room;
    logic [CW-1:0]   len_s [NSTR];
    logic            pick_found;
    logic [SW-1:0]   pick_idx;
    logic [DW-1:0]   tx_word [NCH];

    // per-stream sizing and eligibility
    for (genvar s = 0; s < NSTR; s++) begin : g_stream
        logic [LVL_W-1:0] lvl;
        if (s % 2 == 0) begin : g_tx
            assign lvl = tx_level[(s/2)*LVL_W +: LVL_W];
        end else begin : g_rx
            assign lvl = rx_space[(s/2)*LVL_W +: LVL_W];
        end

        xfer_len_calc #(.LVL_W(LVL_W), .BMAX(BMAX), .CW(CW)) len_i (
            .level    (lvl),
            .burst_ok (far_burst[s]),
            .len      (len_s[s]),
            .has_room (room[s])
        );

        // the stream in flight is not re-picked: its level is one word stale
        assign elig[s] = chan_en[s/2] & far_ready[s] & room[s]
                       & ~((ctl_q.st == ST_XFER) && (ctl_q.sel == SW'(s)));
    end

    for (genvar c = 0; c < NCH; c++) begin : g_txw
        assign tx_word[c] = tx_rd_data[c*DW +: DW];
    end

    xfer_rr_pick #(.N(NSTR), .SW(SW)) pick_i (
        .req   (elig),
        .start (ctl_q.ptr),
        .found (pick_found),
        .idx   (pick_idx)
    );

    // next-state
    always_comb begin
        logic decide;
        logic allow_reg;
        logic go;
        logic go_wr;
        logic go_reg;

        ctl_d     = ctl_q;
        decide    = 1'b0;
        allow_reg = 1'b1;
        go        = 1'b0;
        go_wr     = 1'b0;
        go_reg    = 1'b0;

        unique case (ctl_q.st)
            ST_IDLE: decide = 1'b1;
            ST_TURN: ctl_d.st = ctl_q.is_reg ? ST_REG : ST_XFER;
            ST_XFER: begin
                if (ctl_q.cnt == '0) decide = 1'b1;
                else                 ctl_d.cnt = ctl_q.cnt - CW'(1);
            end
            ST_REG: begin
                decide    = 1'b1;
                allow_reg = 1'b0;
            end
            default: ctl_d.st = ST_IDLE;
        endcase

        if (decide) begin
            if (allow_reg && reg_req) begin
                go           = 1'b1;
                go_reg       = 1'b1;
                go_wr        = reg_we;
                ctl_d.is_reg = 1'b1;
            end else if (pick_found) begin
                go           = 1'b1;
                go_wr        = ~pick_idx[0];
                ctl_d.is_reg = 1'b0;
                ctl_d.sel    = pick_idx;
                ctl_d.cnt    = len_s[pick_idx] - CW'(1);
                ctl_d.ptr    = (pick_idx == SW'(NSTR - 1)) ? '0 : pick_idx + SW'(1);
            end

            if (go) begin
                ctl_d.wr = go_wr;
                if ((ctl_q.st != ST_IDLE) && (go_wr != ctl_q.wr))
                    ctl_d.st = ST_TURN;
                else
                    ctl_d.st = go_reg ? ST_REG : ST_XFER;
            end else begin
                ctl_d.st = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, sel: '0, is_reg: 1'b0, wr: 1'b0, cnt: '0, ptr: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // bus side
    logic            in_data;
    logic            in_reg;
    logic [CHW-1:0]  ch_idx;
    logic [DW-1:0]   dout;

    assign in_data = (ctl_q.st == ST_XFER);
    assign in_reg  = (ctl_q.st == ST_REG);
    assign ch_idx  = CHW'(ctl_q.sel >> 1);

    assign xbus_wr   = (in_data | in_reg) & ctl_q.wr;
    assign xbus_rd   = (in_data | in_reg) & ~ctl_q.wr;
    assign xbus_addr = in_reg ? reg_addr : AW'(DATA_BASE) + AW'(ctl_q.sel);
    assign dout      = in_reg ? reg_wdata : tx_word[ch_idx];
    assign xbus_data = xbus_wr ? dout : {DW{1'bz}};

    for (genvar c = 0; c < NCH; c++) begin : g_strobe
        assign tx_rd_en[c] = in_data &  ctl_q.wr & (ch_idx == CHW'(c));
        assign rx_wr_en[c] = in_data & ~ctl_q.wr & (ch_idx == CHW'(c));
    end

    assign rx_wr_data = xbus_data;
    assign reg_ack    = in_reg;
    assign reg_rdata  = xbus_data;
endmodule

// File: rtl/xfer_ctl_chk.sv
`timescale 1ns/1ps
module xfer_ctl_chk #(
    parameter int NCH  = 2,
    parameter int BMAX = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] chan_en,
    input logic [NCH-1:0] tx_rd_en,
    input logic [NCH-1:0] rx_wr_en,
    input logic           xbus_wr,
    input logic           xbus_rd,
    input logic           reg_req,
    input logic           reg_ack
);
    logic [2*NCH-1:0] strb;
    logic [2*NCH-1:0] strb_prev_q;
    logic [7:0]       run_q;

    assign strb = {tx_rd_en, rx_wr_en};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strb_prev_q <= '0;
            run_q       <= '0;
        end else begin
            strb_prev_q <= strb;
            if (strb == '0)
                run_q <= '0;
            else if (strb == strb_prev_q)
                run_q <= run_q + 8'd1;
            else
                run_q <= 8'd1;
        end
    end

    assert_no_clash_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(xbus_wr && xbus_rd));

    assert_turn_wr_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xbus_wr |=> !xbus_rd);

    assert_turn_rd_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xbus_rd |=> !xbus_wr);

    assert_one_stream_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strb));

    assert_burst_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= 8'(BMAX));

    assert_start_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((strb != '0) && (strb != $past(strb))) |-> (((tx_rd_en | rx_wr_en) & ~chan_en) == '0));

    assert_ack_requested_R12: assert property (@(posedge clk) disable iff (!rst_n)
        reg_ack |-> $past(reg_req));
endmodule

bind xfer_ctl xfer_ctl_chk #(.NCH(NCH), .BMAX(BMAX)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .chan_en  (chan_en),
    .tx_rd_en (tx_rd_en),
    .rx_wr_en (rx_wr_en),
    .xbus_wr  (xbus_wr),
    .xbus_rd  (xbus_rd),
    .reg_req  (reg_req),
    .reg_ack  (reg_ack)
);

// File: tb/xfer_ctl_tb_top.sv
`timescale 1ns/1ps
module xfer_ctl_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n;
    logic [1:0]  chan_en;
    logic [25:0] tx_level;
    logic [63:0] tx_rd_data;
    logic [1:0]  tx_rd_en;
    logic [25:0] rx_space;
    logic [1:0]  rx_wr_en;
    logic [31:0] rx_wr_data;
    logic [3:0]  far_ready;
    logic [3:0]  far_burst;
    logic        reg_req;
    logic        reg_we;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic        reg_ack;
    logic [31:0] reg_rdata;
    logic [7:0]  xbus_addr;
    logic        xbus_wr;
    logic        xbus_rd;
    wire  [31:0] xbus_data;

    xfer_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
        .tx_level(tx_level), .tx_rd_data(tx_rd_data), .tx_rd_en(tx_rd_en),
        .rx_space(rx_space), .rx_wr_en(rx_wr_en), .rx_wr_data(rx_wr_data),
        .far_ready(far_ready), .far_burst(far_burst),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_ack(reg_ack), .reg_rdata(reg_rdata),
        .xbus_addr(xbus_addr), .xbus_wr(xbus_wr), .xbus_rd(xbus_rd), .xbus_data(xbus_data)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // local FIFO and far-side models
    logic [31:0] txmem  [2][256];
    int          tx_head [2];
    int          tx_tail [2];
    logic [31:0] frx    [2][256];
    int          frx_head [2];
    int          frx_tail [2];
    int          far_free [2];
    int          rx_room  [2];
    logic [31:0] far_regs [128];
    logic [31:0] exp_q [4][$];
    int          words   [4];
    int          max_run [4];
    int          cur_s = -1;
    int          cur_run = 0;
    int          last_start = -1;
    bit          rot_on = 1'b0;
    int          rot_bad = 0;
    int          turn_bad = 0;
    bit          prev_wr = 1'b0;
    bit          prev_rd = 1'b0;
    int          seq = 0;
    logic [31:0] far_word;

    always_comb begin
        for (int c = 0; c < 2; c++) begin
            tx_level[c*13 +: 13]   = 13'(tx_tail[c] - tx_head[c]);
            tx_rd_data[c*32 +: 32] = txmem[c][tx_head[c] & 255];
            rx_space[c*13 +: 13]   = 13'(rx_room[c]);
            far_ready[2*c]         = far_free[c] > 0;
            far_burst[2*c]         = far_free[c] >= 16;
            far_ready[2*c+1]       = (frx_tail[c] - frx_head[c]) > 0;
            far_burst[2*c+1]       = (frx_tail[c] - frx_head[c]) >= 16;
        end
    end

    always_comb begin
        far_word = 32'h0;
        if (xbus_addr >= 8'h80) begin
            if (xbus_addr[0]) far_word = frx[xbus_addr[1]][frx_head[xbus_addr[1]] & 255];
        end else begin
            far_word = far_regs[xbus_addr[6:0]];
        end
    end
    assign xbus_data = xbus_rd ? far_word : 32'hzzzz_zzzz;

    // monitor / scoreboard consumer
    always @(negedge clk) begin
        if (rst_n) begin
            int s;
            logic [31:0] e;
            s = -1;
            for (int c = 0; c < 2; c++) begin
                if (tx_rd_en[c]) s = 2*c;
                if (rx_wr_en[c]) s = 2*c + 1;
            end
            if (s >= 0) begin
                words[s]++;
                if (exp_q[s].size() == 0) begin
                    check(1'b0, (s % 2 == 0) ? "R2 unexpected word" : "R3 unexpected word", 32'(s), 32'hffff);
                end else begin
                    e = exp_q[s].pop_front();
                    if (s % 2 == 0) begin
                        check(xbus_wr && !xbus_rd && xbus_addr == 8'(8'h80 + s), "R2 strobe/address",
                              {23'd0, xbus_wr, xbus_addr}, {23'd1, 8'(8'h80 + s)});
                        check(xbus_data == e, "R2 data order", xbus_data, e);
                        tx_head[s/2]++;
                        far_free[s/2]--;
                    end else begin
                        check(xbus_rd && !xbus_wr && xbus_addr == 8'(8'h80 + s), "R3 strobe/address",
                              {23'd0, xbus_rd, xbus_addr}, {23'd1, 8'(8'h80 + s)});
                        check(rx_wr_data == e, "R3 data order", rx_wr_data, e);
                        frx_head[s/2]++;
                        rx_room[s/2]--;
                    end
                end
                if (s == cur_s) begin
                    cur_run++;
                end else begin
                    cur_run = 1;
                    if (rot_on && last_start >= 0 && s != (last_start + 1) % 4) rot_bad++;
                    last_start = s;
                end
                if (cur_run > max_run[s]) max_run[s] = cur_run;
            end
            cur_s = s;
            if ((prev_wr && xbus_rd) || (prev_rd && xbus_wr)) turn_bad++;
            prev_wr = xbus_wr;
            prev_rd = xbus_rd;
            if (xbus_wr && xbus_addr < 8'h80) far_regs[xbus_addr[6:0]] = xbus_data;
        end
    end

    // scoreboard producers
    task automatic push_tx(input int c, input int n);
        @(posedge clk); #2;
        for (int i = 0; i < n; i++) begin
            logic [31:0] w;
            w = {8'(8'h50 + c), 24'(seq)};
            seq++;
            txmem[c][tx_tail[c] & 255] = w;
            tx_tail[c]++;
            exp_q[2*c].push_back(w);
        end
    endtask

    task automatic add_rx(input int c, input int n);
        @(posedge clk); #2;
        for (int i = 0; i < n; i++) begin
            logic [31:0] w;
            w = {8'(8'hA0 + c), 24'(seq)};
            seq++;
            frx[c][frx_tail[c] & 255] = w;
            frx_tail[c]++;
            exp_q[2*c+1].push_back(w);
        end
    endtask

    function automatic int pending();
        return exp_q[0].size() + exp_q[1].size() + exp_q[2].size() + exp_q[3].size();
    endfunction

    task automatic wait_drain(input string tag, input int maxc);
        int k;
        k = 0;
        while (pending() > 0 && k < maxc) begin
            @(negedge clk);
            k++;
        end
        check(pending() == 0, tag, 32'(pending()), 32'd0);
        repeat (4) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_runs();
        for (int i = 0; i < 4; i++) max_run[i] = 0;
    endtask

    task automatic reg_access(input bit we, input logic [7:0] a, input logic [31:0] wd,
                              output logic [31:0] rd, output int w0_at_ack);
        int k;
        @(posedge clk); #2;
        reg_req = 1'b1; reg_we = we; reg_addr = a; reg_wdata = wd;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!reg_ack && k < 200);
        check(reg_ack, we ? "R10 ack seen" : "R11 ack seen", 32'(reg_ack), 32'd1);
        if (we)
            check(xbus_wr && !xbus_rd && xbus_addr == a && xbus_data == wd, "R10 write cycle",
                  xbus_data, wd);
        else
            check(xbus_rd && !xbus_wr && xbus_addr == a, "R11 read cycle", {24'd0, xbus_addr}, {24'd0, a});
        rd = reg_rdata;
        w0_at_ack = words[0];
        reg_req = 1'b0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog (all requirements) actual=hung expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] rdv;
        int w0, base;
        for (int c = 0; c < 2; c++) begin
            tx_head[c] = 0; tx_tail[c] = 0; frx_head[c] = 0; frx_tail[c] = 0;
            far_free[c] = 0; rx_room[c] = 0;
        end
        for (int i = 0; i < 4; i++) begin words[i] = 0; max_run[i] = 0; end
        for (int i = 0; i < 128; i++) far_regs[i] = 32'h0;
        rst_n = 1'b0; chan_en = 2'b00;
        reg_req = 1'b0; reg_we = 1'b0; reg_addr = 8'h0; reg_wdata = 32'h0;
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check(!xbus_wr && !xbus_rd && !reg_ack && tx_rd_en == 2'b00 && rx_wr_en == 2'b00,
              "R1 reset state", {27'd0, xbus_wr, xbus_rd, reg_ack, |tx_rd_en, |rx_wr_en}, 32'd0);

        // R5 full bursts on transmit channel 0
        chan_en = 2'b01;
        far_free[0] = 100;
        push_tx(0, 40);
        wait_drain("R2 transmit drain", 500);
        check(max_run[0] == 16, "R5 burst length", 32'(max_run[0]), 32'd16);

        // R7 burst cut by transmit fill level
        clear_runs();
        push_tx(0, 5);
        wait_drain("R7 short drain", 200);
        check(max_run[0] == 5, "R7 burst cut to tx level", 32'(max_run[0]), 32'd5);

        // R6 single-word mode
        clear_runs();
        far_free[0] = 10;
        push_tx(0, 6);
        wait_drain("R6 single drain", 300);
        check(max_run[0] == 1, "R6 single words", 32'(max_run[0]), 32'd1);

        // R3 receive burst
        clear_runs();
        rx_room[0] = 100;
        add_rx(0, 20);
        wait_drain("R3 receive drain", 500);
        check(max_run[1] == 16, "R5 receive burst length", 32'(max_run[1]), 32'd16);

        // R7 burst cut by receive free space
        clear_runs();
        rx_room[0] = 3;
        base = words[1];
        add_rx(0, 20);
        idle(40);
        check(words[1] - base == 3, "R7 words into 3 free slots", 32'(words[1] - base), 32'd3);
        check(max_run[1] == 3, "R7 burst cut to rx space", 32'(max_run[1]), 32'd3);
        rx_room[0] = 100;
        wait_drain("R3 receive drain after space", 500);

        // R4 disabled channel
        far_free[1] = 100;
        base = words[2];
        push_tx(1, 4);
        idle(50);
        check(words[2] == base, "R4 no words from disabled channel", 32'(words[2] - base), 32'd0);
        check(tx_tail[1] - tx_head[1] == 4, "R4 disabled FIFO untouched",
              32'(tx_tail[1] - tx_head[1]), 32'd4);
        chan_en = 2'b11;
        wait_drain("R4 drain once enabled", 300);

        // R9 rotation with mixed directions, single-word mode
        chan_en = 2'b00;
        idle(4);
        far_free[0] = 8; far_free[1] = 8;
        rx_room[0] = 50; rx_room[1] = 50;
        push_tx(0, 3); push_tx(1, 3);
        add_rx(0, 3); add_rx(1, 3);
        turn_bad = 0; rot_bad = 0; last_start = -1; rot_on = 1'b1;
        @(posedge clk); #2 chan_en = 2'b11;
        wait_drain("R9 rotation drain", 500);
        rot_on = 1'b0;
        check(rot_bad == 0, "R9 grant rotation", 32'(rot_bad), 32'd0);
        check(turn_bad == 0, "R8 idle cycle at turnaround", 32'(turn_bad), 32'd0);

        // R10 / R11 register accesses
        reg_access(1'b1, 8'h12, 32'hCAFE_0012, rdv, w0);
        idle(2);
        check(far_regs[7'h12] == 32'hCAFE_0012, "R10 far register written", far_regs[7'h12], 32'hCAFE_0012);
        reg_access(1'b1, 8'h33, 32'h1234_5678, rdv, w0);
        reg_access(1'b0, 8'h12, 32'h0, rdv, w0);
        check(rdv == 32'hCAFE_0012, "R11 read data", rdv, 32'hCAFE_0012);
        reg_access(1'b0, 8'h33, 32'h0, rdv, w0);
        check(rdv == 32'h1234_5678, "R11 read data second", rdv, 32'h1234_5678);

        // R12 register request during a burst
        chan_en = 2'b01;
        far_free[0] = 100;
        base = words[0];
        push_tx(0, 40);
        while (words[0] - base < 3) @(negedge clk);
        reg_access(1'b1, 8'h20, 32'h0BAD_F00D, rdv, w0);
        check(w0 - base == 16, "R12 grant right after burst", 32'(w0 - base), 32'd16);
        wait_drain("R12 drain rest", 500);
        check(far_regs[7'h20] == 32'h0BAD_F00D, "R12 register write landed", far_regs[7'h20], 32'h0BAD_F00D);
        check(turn_bad == 0, "R8 no direct reversal overall", 32'(turn_bad), 32'd0);

        finish_run();
    end
endmodule